// File: doc/BRIEF.md
# Single-Step Successive Approximation Controller

This block is the digital half of an 8-bit successive-approximation converter. It drives a trial code to an external DAC and reads back one comparator bit that is high whenever the DAC output stands above the analog input. A separate advance request moves the controller forward by exactly one step, so an operator pressing a button, or a free-running enable, can follow the conversion one bit at a time. Only the number of advance requests matters, not how long or how far apart they are.

A ring of one-hot step flags selects the bit under test. The ring has one idle flag, one flag per code bit and one terminal flag. The first advance sets the MSB in the trial code. Each later advance samples the comparator, keeps or clears the bit under test, and sets the next lower bit. After the last decision the final code is copied into a result register and a done flag is raised. One more advance wraps the ring back to idle. Master reset returns everything to the idle state.

Top module: `sar_step_ctrl`

## Requirements
- R1: After master reset (rst_n low at a clock edge) trial_o is 0, step_o is 0x001 (idle, bit 0), done_o is 0 and result_o is 0. This holds even when reset arrives in the middle of a conversion.
- R2: One assertion of adv_i, of any length of one cycle or more, moves the step indicator forward by exactly one position.
- R3: An advance from idle sets only the MSB of trial_o (0x80) and moves step_o to bit 1. The comparator is ignored on this advance. While idle, trial_o is 0.
- R4: While step_o bit k (1..8) is active, code bit 8-k is under test. On an advance, a high cmp_i clears that bit and a low cmp_i keeps it. The next lower bit is then set to 1 and step_o moves to bit k+1.
- R5: step_o always has exactly one bit set.
- R6: The advance that decides the LSB (step_o bit 8) loads result_o with the final code, sets done_o and moves step_o to bit 9. With an ideal comparator (cmp = trial > input code) the result equals the input code, for every code 0..255.
- R7: An advance at step_o bit 9 returns step_o to idle and clears trial_o. result_o and done_o are unchanged.
- R8: The advance that starts a new conversion clears done_o. result_o keeps the previous code until the new final code is loaded.
- R9: trial_o and result_o change only on an advance step. Comparator activity between advances has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| adv_i | input | 1 | Asynchronous advance request (level; one step per assertion) |
| cmp_i | input | 1 | Comparator: high when DAC output is above the input |
| trial_o | output | CODE_W | Trial code to the DAC |
| step_o | output | CODE_W+2 | One-hot step indicator (bit 0 idle, bit CODE_W+1 terminal) |
| done_o | output | 1 | Conversion complete |
| result_o | output | CODE_W | Latched final code |

## Verification
The bench builds the block with its defaults: CODE_W of 8 and two synchroniser stages. This makes all 256 input codes reachable in a sweep. For every code it checks the trial value after each of the ten steps against an arithmetic prediction: the upper bits decided so far, plus the newly set bit. A single run therefore covers every keep or clear decision at every bit position, and every wrap and restart.

// File: rtl/sar_pkg.sv
// Package: shared defaults for the step-driven successive-approximation controller.
// Assumes: nothing; holds constants and helper functions only.
package sar_pkg;

    // Default code width of the converter.
    parameter int unsigned SAR_DEF_CODE_W = 8;

    // Default depth of the advance-request synchroniser.
    parameter int unsigned SAR_DEF_SYNC = 2;

    // Number of one-hot step flags: idle, one per bit, terminal.
    function automatic int unsigned sar_steps(input int unsigned code_w);
        return code_w + 2;
    endfunction

endpackage

// File: rtl/sar_adv_sync.sv
// Module: sar_adv_sync
// Synchronises an asynchronous advance level into the clock domain and emits a
// single-cycle pulse on each rising edge of the synchronised level.
// Assumes: SYNC_STAGES >= 2; rst_n is synchronous and active low.
module sar_adv_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_raw,
    output logic adv_pulse
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the raw request through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], adv_raw};
        end
    end

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // One pulse per low-to-high transition of the synchronised level.
    always_comb begin
        adv_pulse = sync_q[SYNC_STAGES-1] & ~prev_q;
    end

endmodule

// File: rtl/sar_step_ring.sv
// Module: sar_step_ring
// One-hot step sequencer. It rotates by one position per advance pulse, and the
// terminal flag wraps back to idle. Reset loads the idle flag.
// Assumes: NSTEPS >= 3; advance is a single-cycle pulse.
module sar_step_ring #(
    parameter int unsigned NSTEPS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [NSTEPS-1:0] step
);

    logic [NSTEPS-1:0] step_q;
    logic [NSTEPS-1:0] step_nxt;

    // Next-state rotation: each flag takes its lower neighbour, idle takes terminal.
    always_comb begin
        step_nxt[0] = step_q[NSTEPS-1];
    end

    for (genvar i = 1; i < NSTEPS; i++) begin : g_rot
        // Each non-idle flag follows the flag below it.
        always_comb begin
            step_nxt[i] = step_q[i-1];
        end
    end

    // Register the ring; it moves only on an advance pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= {{(NSTEPS-1){1'b0}}, 1'b1};
        end else if (adv) begin
            step_q <= step_nxt;
        end
    end

    // Expose the current step.
    always_comb begin
        step = step_q;
    end

endmodule

// File: rtl/sar_trial_reg.sv
// Module: sar_trial_reg
// Trial-code register. Each bit is set when its step begins and cleared when the
// comparator reports the trial above the input while that bit is under test.
// The terminal step clears the whole code.
// Assumes: step is one-hot with CODE_W+2 flags, bit 0 idle, bit CODE_W+1 terminal;
// code bit b is under test while step flag CODE_W-b is active.
module sar_trial_reg #(
    parameter int unsigned CODE_W = 8,
    localparam int unsigned NSTEPS = CODE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              cmp,
    input  logic [NSTEPS-1:0] step,
    output logic [CODE_W-1:0] trial,
    output logic [CODE_W-1:0] trial_nxt
);

    logic [CODE_W-1:0] trial_q;
    logic              wipe;

    // The terminal flag clears every bit on the wrapping advance.
    always_comb begin
        wipe = step[NSTEPS-1];
    end

    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
        logic begin_test;
        logic under_test;

        // Decode which phase this bit is in.
        always_comb begin
            begin_test = step[CODE_W-b-1];
            under_test = step[CODE_W-b];
        end

        // Next value of this bit if an advance happens now.
        always_comb begin
            if (wipe) begin
                trial_nxt[b] = 1'b0;
            end else if (begin_test) begin
                trial_nxt[b] = 1'b1;
            end else if (under_test && cmp) begin
                trial_nxt[b] = 1'b0;
            end else begin
                trial_nxt[b] = trial_q[b];
            end
        end
    end

    // Register the trial code on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial_q <= '0;
        end else if (adv) begin
            trial_q <= trial_nxt;
        end
    end

    // Expose the current trial.
    always_comb begin
        trial = trial_q;
    end

endmodule

// File: rtl/sar_step_ctrl.sv
// Module: sar_step_ctrl (top)
// Single-step successive-approximation controller: an advance synchroniser, a
// one-hot step ring, a trial register, and the result and done latch.
// Assumes: cmp_i is high when the DAC output for trial_o exceeds the input and is
// settled when an advance is applied; rst_n is synchronous, active low.
module sar_step_ctrl
    import sar_pkg::*;
#(
    parameter int unsigned CODE_W      = SAR_DEF_CODE_W,
    parameter int unsigned SYNC_STAGES = SAR_DEF_SYNC,
    localparam int unsigned NSTEPS     = CODE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              cmp_i,
    output logic [CODE_W-1:0] trial_o,
    output logic [NSTEPS-1:0] step_o,
    output logic              done_o,
    output logic [CODE_W-1:0] result_o
);

    logic              adv_pulse;
    logic [NSTEPS-1:0] step;
    logic [CODE_W-1:0] trial;
    logic [CODE_W-1:0] trial_nxt;
    logic [CODE_W-1:0] result_q;
    logic              done_q;

    sar_adv_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_raw  (adv_i),
        .adv_pulse(adv_pulse)
    );

    sar_step_ring #(.NSTEPS(NSTEPS)) u_ring (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (adv_pulse),
        .step (step)
    );

    sar_trial_reg #(.CODE_W(CODE_W)) u_trial (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv_pulse),
        .cmp      (cmp_i),
        .step     (step),
        .trial    (trial),
        .trial_nxt(trial_nxt)
    );

    // Capture the final code when the LSB decision is made.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (adv_pulse && step[CODE_W]) begin
            result_q <= trial_nxt;
        end
    end

    // Raise done on the last decision; drop it when a new conversion starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (adv_pulse && step[CODE_W]) begin
            done_q <= 1'b1;
        end else if (adv_pulse && step[0]) begin
            done_q <= 1'b0;
        end
    end

    // Drive the outputs.
    always_comb begin
        trial_o  = trial;
        step_o   = step;
        done_o   = done_q;
        result_o = result_q;
    end

endmodule

// File: rtl/sar_step_ctrl_chk.sv
// Module: sar_step_ctrl_chk
// Property checker attached to sar_step_ctrl by bind; observes ports and the
// internal advance pulse.
// Assumes: same CODE_W as the bound instance.
module sar_step_ctrl_chk #(
    parameter int unsigned CODE_W = 8,
    localparam int unsigned NSTEPS = CODE_W + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adv_pulse,
    input logic [CODE_W-1:0] trial_o,
    input logic [NSTEPS-1:0] step_o,
    input logic              done_o,
    input logic [CODE_W-1:0] result_o
);

    assert_step_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(step_o) == 1);

    assert_idle_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_pulse && step_o[0]) |=> step_o[1]);

    assert_idle_trial_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_o[0] |-> (trial_o == '0));

    assert_done_at_term_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> step_o[NSTEPS-1]);

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv_pulse && step_o[CODE_W]) |=> $stable(result_o));

    assert_trial_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_pulse |=> $stable(trial_o));

endmodule

bind sar_step_ctrl sar_step_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_pulse(adv_pulse),
    .trial_o  (trial_o),
    .step_o   (step_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/sar_step_ctrl_test.sv
module sar_step_ctrl_test;

    localparam int W  = 8;
    localparam int NS = W + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adv = 1'b0;
    logic          cmp;
    logic          ovr_en = 1'b0;
    logic          ovr_val = 1'b0;
    int            vin = 0;
    logic [W-1:0]  trial;
    logic [NS-1:0] step;
    logic          done;
    logic [W-1:0]  result;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    // Ideal quantizer model: high when the trial stands above the input.
    assign cmp = ovr_en ? ovr_val : (int'(trial) > vin);

    sar_step_ctrl uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (adv),
        .cmp_i   (cmp),
        .trial_o (trial),
        .step_o  (step),
        .done_o  (done),
        .result_o(result)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic press(input int len);
        @(negedge clk);
        adv = 1'b1;
        repeat (len) @(negedge clk);
        adv = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int prev;
        do_reset();
        // R1: reset state
        chk(trial == 0, "R1 trial", int'(trial), 0);
        chk(step == NS'(1), "R1 step", int'(step), 1);
        chk(done == 0, "R1 done", int'(done), 0);
        chk(result == 0, "R1 result", int'(result), 0);

        // R9: comparator toggling without advance has no effect
        ovr_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            ovr_val = ~ovr_val;
            @(negedge clk);
        end
        chk(trial == 0 && step == NS'(1), "R9 no-advance", int'(trial), 0);

        // R3: idle advance ignores a high comparator, sets MSB
        ovr_val = 1'b1;
        press(1);
        chk(trial == 8'h80, "R3 msb set", int'(trial), 'h80);
        chk(step == NS'(2), "R3 step1", int'(step), 2);
        ovr_en = 1'b0;

        // R2: long press moves exactly one step
        vin = 8'hFF;
        press(25);
        chk(step == NS'(4), "R2 long press", int'(step), 4);
        chk(trial == 8'hC0, "R2 trial", int'(trial), 'hC0);

        // R1: reset mid-conversion
        do_reset();
        chk(trial == 0 && step == NS'(1) && done == 0 && result == 0,
            "R1 mid reset", int'(trial), 0);

        // Exhaustive sweep of input codes (R4, R6, R7, R8)
        prev = 0;
        for (int v = 0; v < 256; v++) begin
            vin = v;
            press(1 + (v % 3));
            chk(trial == 8'h80, "R3 start", int'(trial), 'h80);
            chk(done == 0, "R8 done cleared", int'(done), 0);
            chk(int'(result) == prev, "R8 result kept", int'(result), prev);
            for (int k = 0; k < W; k++) begin
                int hi;
                press(1);
                hi = v & ((8'hFF << (7 - k)) & 8'hFF);
                if (k < W - 1) begin
                    chk(int'(trial) == (hi | (1 << (6 - k))), "R4 trial",
                        int'(trial), hi | (1 << (6 - k)));
                    chk(step == NS'(1 << (k + 2)), "R4 step", int'(step), 1 << (k + 2));
                end else begin
                    chk(int'(result) == v, "R6 result", int'(result), v);
                    chk(done == 1, "R6 done", int'(done), 1);
                    chk(step == NS'(1 << (NS - 1)), "R6 step", int'(step), 1 << (NS - 1));
                end
            end
            press(1);
            chk(step == NS'(1) && trial == 0, "R7 wrap", int'(step), 1);
            chk(int'(result) == v && done == 1, "R7 hold", int'(result), v);
            // R5: one-hot indicator sampled at idle
            chk($countones(step) == 1, "R5 onehot", int'(step), 1);
            prev = v;
        end

        summary();
        $finish;
    end

endmodule